// File: doc/BRIEF.md
# Multi-mode mantissa rounding unit

This combinational unit takes a mantissa that still carries two extra low-order positions, a guard position and, below it, a round position, together with a separate sticky bit summarising everything shifted out further down. It drops the two extra positions, then decides from the sign and a two-bit direction code whether to add one at the new least significant position. It is meant to sit between an internal wide-precision result and the packing logic of a floating-point datapath.

The unit reports whether it rounded up and raises two status flags: one for any loss of precision and one for a loss of precision that led to an increment. When the increment ripples through an all-ones mantissa, the result wraps to zero and the carry appears on a separate output. The unit does not renormalise that value; the exponent adjustment is left to the caller.

Top module: `mant_round`

## Requirements
- R1: `mant_out` equals `mant_in` shifted right by two (bit 1 is the guard, bit 0 the round) whenever no increment takes place, and `carry_out` is then 0.
- R2: When guard, round and `sticky_in` are all 0, no flag is raised, `round_up` is 0 and the shifted mantissa is passed through.
- R3: When any of guard, round or `sticky_in` is 1, both `inexact` and `frac_inexact` are 1 in every mode.
- R4: With `mode_in` = 2'b00 (nearest, ties to even) the unit increments exactly when guard is 1 and at least one of round, sticky or the shifted least significant bit is 1.
- R5: With `mode_in` = 2'b01 (toward zero) the unit never increments.
- R6: With `mode_in` = 2'b10 (toward plus infinity) the unit increments exactly when the input is inexact and `sign_in` is 0.
- R7: With `mode_in` = 2'b11 (toward minus infinity) the unit increments exactly when the input is inexact and `sign_in` is 1.
- R8: On an increment, `{carry_out, mant_out}` equals the shifted mantissa plus one, and `round_up` and `frac_rounded` are both 1; otherwise both are 0.
- R9: Incrementing an all-ones shifted mantissa yields `mant_out` = 0 with `carry_out` = 1, with no renormalisation.
- R10: `round_up` is never 1 while `inexact` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_in | input | MANT_W+2 | Mantissa with guard (bit 1) and round (bit 0) positions |
| sticky_in | input | 1 | OR of all bits below the round position |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| mode_in | input | 2 | Direction code: 00 nearest, 01 zero, 10 plus infinity, 11 minus infinity |
| mant_out | output | MANT_W | Shifted and possibly incremented mantissa |
| carry_out | output | 1 | Carry out of the increment into the next power of two |
| round_up | output | 1 | An increment was applied |
| inexact | output | 1 | Precision was lost |
| frac_inexact | output | 1 | Fraction-level precision loss flag |
| frac_rounded | output | 1 | Fraction was rounded up in magnitude |

## Verification
The two functions that fall in the same evaluation are the rounding decision and the carry propagation: a halfway case with an odd retained bit on an all-ones mantissa must both choose to increment and wrap to zero with a carry out. The bench provokes this, and every other mix, by sweeping all mantissa, sticky, sign and mode combinations of a four-bit configuration. Each outcome is judged against a result computed arithmetically in the bench as truncated value plus a decision bit, split into the low bits and the carry.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

  typedef enum logic [1:0] {
    RDIR_NEAREST = 2'b00,
    RDIR_ZERO    = 2'b01,
    RDIR_POS_INF = 2'b10,
    RDIR_NEG_INF = 2'b11
  } rdir_e;

endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
  import mant_round_pkg::*;
(
  input  logic  guard_i,
  input  logic  rbit_i,
  input  logic  sticky_i,
  input  logic  lsb_i,
  input  logic  neg_i,
  input  rdir_e dir_i,
  output logic  lost_o,
  output logic  bump_o
);

  logic above_half;

  always_comb begin
    lost_o     = guard_i | rbit_i | sticky_i;
    above_half = rbit_i | sticky_i | lsb_i;
    unique case (dir_i)
      RDIR_NEAREST: bump_o = guard_i & above_half;
      RDIR_ZERO:    bump_o = 1'b0;
      RDIR_POS_INF: bump_o = lost_o & ~neg_i;
      RDIR_NEG_INF: bump_o = lost_o &  neg_i;
      default:      bump_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/mant_round_incr.sv
module mant_round_incr #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH:0] chain;

  assign chain[0] = inc_i;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign sum_o[b]    = val_i[b] ^ chain[b];
    assign chain[b+1]  = val_i[b] & chain[b];
  end

  assign cout_o = chain[WIDTH];

endmodule

// File: rtl/mant_round.sv
module mant_round
  import mant_round_pkg::*;
#(
  parameter int MANT_W = 24
) (
  input  logic [MANT_W+1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        mode_in,
  output logic [MANT_W-1:0] mant_out,
  output logic              carry_out,
  output logic              round_up,
  output logic              inexact,
  output logic              frac_inexact,
  output logic              frac_rounded
);

  localparam int EXTRA_W = 2;

  logic [MANT_W-1:0] kept;
  logic              lost;
  logic              bump;

  assign kept = mant_in[MANT_W+EXTRA_W-1:EXTRA_W];

  mant_round_decide u_decide (
    .guard_i  (mant_in[1]),
    .rbit_i   (mant_in[0]),
    .sticky_i (sticky_in),
    .lsb_i    (kept[0]),
    .neg_i    (sign_in),
    .dir_i    (rdir_e'(mode_in)),
    .lost_o   (lost),
    .bump_o   (bump)
  );

  mant_round_incr #(.WIDTH(MANT_W)) u_incr (
    .val_i  (kept),
    .inc_i  (bump),
    .sum_o  (mant_out),
    .cout_o (carry_out)
  );

  assign round_up     = bump;
  assign frac_rounded = bump;
  assign inexact      = lost;
  assign frac_inexact = lost;

endmodule

// File: rtl/mant_round_chk.sv
module mant_round_chk #(
  parameter int MANT_W = 24
) (
  input logic [MANT_W+1:0] mant_in,
  input logic              sticky_in,
  input logic              sign_in,
  input logic [1:0]        mode_in,
  input logic [MANT_W-1:0] mant_out,
  input logic              carry_out,
  input logic              round_up,
  input logic              inexact,
  input logic              frac_inexact,
  input logic              frac_rounded
);

  logic [MANT_W:0] trunc_ext;
  logic            exact;

  always_comb begin
    trunc_ext = {1'b0, mant_in[MANT_W+1:2]};
    exact     = (mant_in[1:0] == 2'b00) && !sticky_in;

    if (exact)
      assert_exact_quiet_R2: assert (!inexact && !frac_inexact && !round_up
                                     && {carry_out, mant_out} == trunc_ext);
    if (!exact)
      assert_lossy_flags_R3: assert (inexact && frac_inexact);
    if (mode_in == 2'b01)
      assert_zero_never_up_R5: assert (!round_up);
    if (mode_in == 2'b00 && !mant_in[1])
      assert_near_below_half_R4: assert (!round_up);
    if (mode_in == 2'b10 && sign_in)
      assert_pos_inf_neg_down_R6: assert (!round_up);
    if (mode_in == 2'b11 && !sign_in)
      assert_neg_inf_pos_down_R7: assert (!round_up);
    if (round_up)
      assert_incr_value_R8: assert ({carry_out, mant_out} == trunc_ext + 1'b1
                                    && frac_rounded);
    if (!round_up)
      assert_pass_value_R1: assert ({carry_out, mant_out} == trunc_ext);
    if (round_up)
      assert_up_needs_loss_R10: assert (inexact);
  end

endmodule

bind mant_round mant_round_chk #(.MANT_W(MANT_W)) u_mant_round_chk (
  .mant_in      (mant_in),
  .sticky_in    (sticky_in),
  .sign_in      (sign_in),
  .mode_in      (mode_in),
  .mant_out     (mant_out),
  .carry_out    (carry_out),
  .round_up     (round_up),
  .inexact      (inexact),
  .frac_inexact (frac_inexact),
  .frac_rounded (frac_rounded)
);

// File: tb/mant_round_bench.sv
module mant_round_bench;

  localparam int W = 4;

  logic clk;
  logic [W+1:0] mant_in;
  logic         sticky_in, sign_in;
  logic [1:0]   mode_in;
  logic [W-1:0] mant_out;
  logic         carry_out, round_up, inexact, frac_inexact, frac_rounded;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  mant_round #(.MANT_W(W)) u_mant_round (
    .mant_in      (mant_in),
    .sticky_in    (sticky_in),
    .sign_in      (sign_in),
    .mode_in      (mode_in),
    .mant_out     (mant_out),
    .carry_out    (carry_out),
    .round_up     (round_up),
    .inexact      (inexact),
    .frac_inexact (frac_inexact),
    .frac_rounded (frac_rounded)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s m=%0h s=%0d sg=%0d md=%0d actual=%0h expected=%0h",
               tag, mant_in, sticky_in, sign_in, mode_in, act, exp);
    end
  endtask

  task automatic apply(input int m, input int s, input int sg, input int md);
    @(posedge clk);
    #1;
    mant_in   = (W+2)'(m);
    sticky_in = s[0];
    sign_in   = sg[0];
    mode_in   = md[1:0];
    @(negedge clk);
  endtask

  initial begin
    mant_in = '0; sticky_in = 0; sign_in = 0; mode_in = 2'b00;
    // initial all-zero vector
    apply(0, 0, 0, 0);
    check(mant_out == 0 && !carry_out, "R1 zero input", {carry_out, mant_out}, 0);
    check(!inexact && !round_up, "R2 zero flags", {inexact, round_up}, 0);

    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < (1 << (W + 2)); m++) begin
            int trunc, g, r, lost, inc, res, act_v;
            string mtag;
            apply(m, s, sg, md);
            trunc = m >> 2;
            g     = (m >> 1) & 1;
            r     = m & 1;
            lost  = g | r | s;
            case (md)
              0: begin inc = g & (r | s | (trunc & 1)); mtag = "R4 nearest"; end
              1: begin inc = 0;                          mtag = "R5 zero"; end
              2: begin inc = lost & (sg == 0 ? 1 : 0);   mtag = "R6 plus"; end
              default: begin inc = lost & sg;            mtag = "R7 minus"; end
            endcase
            res   = trunc + inc;
            act_v = {carry_out, mant_out};
            check(round_up == inc[0], mtag, round_up, inc);
            if (inc == 0)
              check(act_v == trunc, "R1 pass", act_v, trunc);
            else if (trunc == (1 << W) - 1)
              check(act_v == res && mant_out == 0 && carry_out, "R9 wrap", act_v, res);
            else
              check(act_v == res, "R8 incr", act_v, res);
            check(frac_rounded == inc[0], "R8 frac_rounded", frac_rounded, inc);
            if (lost == 0)
              check(!inexact && !frac_inexact && !round_up, "R2 exact",
                    {inexact, frac_inexact, round_up}, 0);
            else
              check(inexact && frac_inexact, "R3 lossy", {inexact, frac_inexact}, 3);
            check(!(round_up && !inexact), "R10 up implies loss", {round_up, inexact}, 0);
          end
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule